// File: doc/BRIEF.md
# Lookup-Table Netlist 4-Bit Adder

This block adds two 4-bit unsigned operands and returns the low four bits of their sum. It uses no behavioural `+` operator. It is a hand-built netlist of generic 4-input lookup-table cells and one 2:1 multiplexer. Each cell holds a 16-bit truth table and returns the table bit addressed by its inputs. The result is exactly what a synthesis flow would produce for a small adder on a LUT-based fabric, so the structure can be studied and reused cell by cell.

The netlist has two halves. The lower half takes operand bits 0 and 1. It produces sum bits 0 and 1, and it also produces an active-low flag that says whether a carry leaves bit 1. The upper half takes operand bits 2 and 3 plus that flag, and no other signal from the lower half. Sum bit 3 is computed twice, once for each value of the second operand's top bit. That top bit then selects one of the two results through the multiplexer. The whole block is combinational and has no clock or reset.

Top module: `lutadd4`

## Requirements
- R1: A lookup-table cell with inputs A, B, C, D returns bit {D,C,B,A} of its 16-bit table, with D the most significant index bit and A the least.
- R2: sum[0] equals a[0] XOR b[0]. Its cell holds table 16'h0FF0, with a[0] on C, b[0] on D, and A and B tied to 0.
- R3: sum[1] equals a[1] XOR b[1] XOR (a[0] AND b[0]). Its cell holds table 16'h8778, with a[0], b[0], a[1], b[1] on A, B, C, D.
- R4: The lower half drives an active-low carry flag. The flag is 1 when a[1:0] + b[1:0] is below 4, and 0 when a carry leaves bit 1.
- R5: sum[2] equals a[2] XOR b[2] XOR the carry into bit 2. The carry into bit 2 is the inverse of the R4 flag.
- R6: Two candidate cells share the inputs (flag on A, a[2] on B, b[2] on C, a[3] on D). One gives sum[3] for b[3]=0 (table 16'h2BD4). The other gives sum[3] for b[3]=1 (the bitwise complement, 16'hD42B).
- R7: sum[3] is the b[3]=1 candidate when b[3] is 1, and the b[3]=0 candidate otherwise.
- R8: For every pair of operands, sum equals (a + b) mod 16. The carry out of bit 3 is dropped.
- R9: The upper half depends on the lower operand bits only through the R4 flag. For given a[3:2], b[3:2] and flag f, its two outputs equal (a[3:2] + b[3:2] + (1 - f)) mod 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First unsigned operand |
| b | input | 4 | Second unsigned operand |
| sum | output | 4 | Low four bits of a + b |

## Verification
The hardest case to reach from the ports is a fault in a bit-3 candidate table for an input combination the multiplexer never selects. Each candidate's entry is only visible for one value of b[3]. A fault in that entry can also be hidden whenever the carry flag and bit-2 operands cannot occur together through the lower half. The bench therefore sweeps all 256 operand pairs through a scoreboard. It also drives standalone copies of the candidate cells and of the upper half directly, with every value of the flag, so that every table entry is observed independently of the lower half.

// File: rtl/lutadd_pkg.sv
package lutadd_pkg;

  localparam int LUT_IN   = 4;
  localparam int LUT_SIZE = 1 << LUT_IN;
  localparam int OPW      = 4;
  localparam int HALFW    = OPW / 2;

  typedef logic [LUT_SIZE-1:0] lut_init_t;

  // Truth tables, indexed by {D,C,B,A}
  localparam lut_init_t INIT_BIT0    = 16'h0FF0;
  localparam lut_init_t INIT_BIT1    = 16'h8778;
  localparam lut_init_t INIT_NCARRY  = 16'h077F;
  localparam lut_init_t INIT_BIT2    = 16'h3CC3;
  localparam lut_init_t INIT_BIT3_B0 = 16'h2BD4;
  localparam lut_init_t INIT_BIT3_B1 = ~INIT_BIT3_B0;

  // Reference arithmetic used by the in-line assertions
  function automatic logic [OPW-1:0] ref_sum(input logic [OPW-1:0] x,
                                             input logic [OPW-1:0] y);
    logic [OPW:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[OPW-1:0];
  endfunction

  function automatic logic ref_carry_lo(input logic [HALFW-1:0] x,
                                        input logic [HALFW-1:0] y);
    logic [HALFW:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[HALFW];
  endfunction

  function automatic logic ref_top_bit(input logic ncarry, input logic a2,
                                       input logic b2, input logic a3,
                                       input logic b3);
    logic c3;
    c3 = (a2 & b2) | ((a2 ^ b2) & ~ncarry);
    return a3 ^ b3 ^ c3;
  endfunction

endpackage

// File: rtl/lutadd_lut4.sv
module lutadd_lut4 import lutadd_pkg::*; #(
  parameter lut_init_t INIT = '0
) (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic y
);

  logic [LUT_IN-1:0] idx;

  assign idx = {d, c, b, a};
  assign y   = INIT[idx];

endmodule

// File: rtl/lutadd_mux2.sv
module lutadd_mux2 (
  input  logic in0,
  input  logic in1,
  input  logic sel,
  output logic y
);

  assign y = sel ? in1 : in0;

endmodule

// File: rtl/lutadd_lo.sv
module lutadd_lo import lutadd_pkg::*; #(
  parameter lut_init_t BIT0_INIT   = INIT_BIT0,
  parameter lut_init_t BIT1_INIT   = INIT_BIT1,
  parameter lut_init_t NCARRY_INIT = INIT_NCARRY
) (
  input  logic [HALFW-1:0] a_lo,
  input  logic [HALFW-1:0] b_lo,
  output logic [HALFW-1:0] sum_lo,
  output logic             ncarry_n
);

  lutadd_lut4 #(.INIT(BIT0_INIT)) u_bit0 (
    .a(1'b0), .b(1'b0), .c(a_lo[0]), .d(b_lo[0]), .y(sum_lo[0])
  );

  lutadd_lut4 #(.INIT(BIT1_INIT)) u_bit1 (
    .a(a_lo[0]), .b(b_lo[0]), .c(a_lo[1]), .d(b_lo[1]), .y(sum_lo[1])
  );

  lutadd_lut4 #(.INIT(NCARRY_INIT)) u_ncarry (
    .a(a_lo[0]), .b(b_lo[0]), .c(a_lo[1]), .d(b_lo[1]), .y(ncarry_n)
  );

  always_comb begin
    AST_BIT0_SUM: assert (sum_lo[0] == (a_lo[0] ^ b_lo[0])); // R2
  end

  always_comb begin
    AST_BIT1_SUM: assert (sum_lo[1] == (a_lo[1] ^ b_lo[1] ^ (a_lo[0] & b_lo[0]))); // R3
  end

  always_comb begin
    AST_NCARRY_FLAG: assert (ncarry_n == ~ref_carry_lo(a_lo, b_lo)); // R4
  end

endmodule

// File: rtl/lutadd_hi.sv
module lutadd_hi import lutadd_pkg::*; #(
  parameter lut_init_t BIT2_INIT = INIT_BIT2,
  parameter lut_init_t TOP0_INIT = INIT_BIT3_B0,
  parameter lut_init_t TOP1_INIT = INIT_BIT3_B1
) (
  input  logic [HALFW-1:0] a_hi,
  input  logic [HALFW-1:0] b_hi,
  input  logic             ncarry_n,
  output logic [HALFW-1:0] sum_hi
);

  // cand[k]: top sum bit assuming the second operand's top bit equals k
  logic [1:0] cand;

  lutadd_lut4 #(.INIT(BIT2_INIT)) u_bit2 (
    .a(1'b0), .b(ncarry_n), .c(a_hi[0]), .d(b_hi[0]), .y(sum_hi[0])
  );

  for (genvar k = 0; k < 2; k++) begin : g_cand
    localparam lut_init_t CINIT = (k == 1) ? TOP1_INIT : TOP0_INIT;
    lutadd_lut4 #(.INIT(CINIT)) u_cand (
      .a(ncarry_n), .b(a_hi[0]), .c(b_hi[0]), .d(a_hi[1]), .y(cand[k])
    );
  end

  lutadd_mux2 u_top_mux (
    .in0(cand[0]), .in1(cand[1]), .sel(b_hi[1]), .y(sum_hi[1])
  );

  always_comb begin
    AST_BIT2_SUM: assert (sum_hi[0] == (a_hi[0] ^ b_hi[0] ^ ~ncarry_n)); // R5
  end

  always_comb begin
    AST_CAND_LOW: assert (cand[0] == ref_top_bit(ncarry_n, a_hi[0], b_hi[0], a_hi[1], 1'b0)); // R6
  end

  always_comb begin
    AST_CAND_HIGH: assert (cand[1] == ref_top_bit(ncarry_n, a_hi[0], b_hi[0], a_hi[1], 1'b1)); // R6
  end

  always_comb begin
    AST_TOP_PICK: assert (sum_hi[1] == ref_top_bit(ncarry_n, a_hi[0], b_hi[0], a_hi[1], b_hi[1])); // R7
  end

endmodule

// File: rtl/lutadd4.sv
module lutadd4 import lutadd_pkg::*; (
  input  logic [3:0] a,
  input  logic [3:0] b,
  output logic [3:0] sum
);

  logic carry_mid_n;   // only link between the two halves

  lutadd_lo u_lo (
    .a_lo    (a[HALFW-1:0]),
    .b_lo    (b[HALFW-1:0]),
    .sum_lo  (sum[HALFW-1:0]),
    .ncarry_n(carry_mid_n)
  );

  lutadd_hi u_hi (
    .a_hi    (a[OPW-1:HALFW]),
    .b_hi    (b[OPW-1:HALFW]),
    .ncarry_n(carry_mid_n),
    .sum_hi  (sum[OPW-1:HALFW])
  );

  always_comb begin
    AST_MOD16_SUM: assert (sum == ref_sum(a, b)); // R8
  end

endmodule

// File: tb/lutadd4_tb.sv
module lutadd4_tb;
  import lutadd_pkg::*;

  localparam lut_init_t PROBE_INIT = 16'hB61D;

  typedef struct {
    int a;
    int b;
    int exp;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // DUT
  logic [3:0] a_i = 4'd0;
  logic [3:0] b_i = 4'd0;
  logic [3:0] sum_o;

  lutadd4 u_dut (.a(a_i), .b(b_i), .sum(sum_o));

  // Standalone cell for R1
  logic [3:0] p_idx = 4'd0;
  logic       p_y;
  lutadd_lut4 #(.INIT(PROBE_INIT)) u_probe (
    .a(p_idx[0]), .b(p_idx[1]), .c(p_idx[2]), .d(p_idx[3]), .y(p_y)
  );

  // Lower half for R4
  logic [1:0] lo_a = 2'd0, lo_b = 2'd0, lo_sum;
  logic       lo_nc;
  lutadd_lo u_lo_chk (.a_lo(lo_a), .b_lo(lo_b), .sum_lo(lo_sum), .ncarry_n(lo_nc));

  // Candidate cells for R6: A=flag, B=a2, C=b2, D=a3
  logic [3:0] c_in = 4'd0;
  logic       c0_y, c1_y;
  lutadd_lut4 #(.INIT(INIT_BIT3_B0)) u_cand0 (
    .a(c_in[0]), .b(c_in[1]), .c(c_in[2]), .d(c_in[3]), .y(c0_y)
  );
  lutadd_lut4 #(.INIT(INIT_BIT3_B1)) u_cand1 (
    .a(c_in[0]), .b(c_in[1]), .c(c_in[2]), .d(c_in[3]), .y(c1_y)
  );

  // Upper half for R9
  logic [1:0] hi_a = 2'd0, hi_b = 2'd0, hi_sum;
  logic       hi_nc = 1'b1;
  lutadd_hi u_hi_chk (.a_hi(hi_a), .b_hi(hi_b), .ncarry_n(hi_nc), .sum_hi(hi_sum));

  // Scoreboard
  sb_item_t sb_q[$];

  task automatic drive_pair(input int x, input int y);
    sb_item_t it;
    @(posedge clk);
    a_i <= 4'(x);
    b_i <= 4'(y);
    it.a   = x;
    it.b   = y;
    it.exp = (x + y) % 16;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      sb_item_t it;
      int c1, c2;
      it = sb_q.pop_front();
      c1 = ((it.a % 4) + (it.b % 4)) / 4;
      c2 = ((it.a % 8) + (it.b % 8)) / 8;
      check("R2 sum[0]", int'(sum_o[0]), (it.a + it.b) % 2);
      check("R3 sum[1]", int'(sum_o[1]), (((it.a % 4) + (it.b % 4)) / 2) % 2);
      check("R5 sum[2]", int'(sum_o[2]), ((it.a / 4) % 2 + (it.b / 4) % 2 + c1) % 2);
      check("R7 sum[3]", int'(sum_o[3]), ((it.a / 8) + (it.b / 8) + c2) % 2);
      check("R8 sum", int'(sum_o), it.exp);
    end
  end

  initial begin
    bit done;
    repeat (3) @(posedge clk);
    rst <= 1'b0;

    // Reset-state / idle check: zero operands give zero (R8)
    @(negedge clk);
    check("R8 idle zero", int'(sum_o), 0);

    // Corner pairs first, then the full sweep (R2 R3 R5 R7 R8)
    drive_pair(15, 1);
    drive_pair(15, 15);
    drive_pair(3, 1);
    drive_pair(7, 1);
    drive_pair(8, 8);
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        drive_pair(x, y);
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = (sb_q.size() == 0);
    end

    // R1: table addressing order {D,C,B,A}
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      p_idx <= 4'(i);
      @(negedge clk);
      check("R1 lut index", int'(p_y), (int'(PROBE_INIT) >> i) % 2);
    end

    // R4: active-low carry flag out of bit 1
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        @(posedge clk);
        lo_a <= 2'(x);
        lo_b <= 2'(y);
        @(negedge clk);
        check("R4 carry flag", int'(lo_nc), (x + y < 4) ? 1 : 0);
      end

    // R6: both candidates against top-bit reference for each b3 value
    for (int i = 0; i < 16; i++) begin
      int nc, a2, b2, a3, c3;
      nc = i % 2; a2 = (i / 2) % 2; b2 = (i / 4) % 2; a3 = i / 8;
      c3 = (a2 + b2 + (1 - nc)) / 2;
      @(posedge clk);
      c_in <= 4'(i);
      @(negedge clk);
      check("R6 cand b3=0", int'(c0_y), (a3 + c3) % 2);
      check("R6 cand b3=1", int'(c1_y), (a3 + 1 + c3) % 2);
    end

    // R9: upper half driven only by its own bits and the flag
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 16; i++) begin
        @(posedge clk);
        hi_a  <= 2'(i % 4);
        hi_b  <= 2'(i / 4);
        hi_nc <= 1'(f);
        @(negedge clk);
        check("R9 upper half", int'(hi_sum), ((i % 4) + (i / 4) + (1 - f)) % 4);
      end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule